// File: doc/BRIEF.md
# System Sleep State Sequencer

This block walks a platform between its working state, the sleeping states S1, S3 and S4, soft off (S5) and mechanical off. Software picks a target with a three-bit sleep type code and a one-cycle go strobe. The sequencer then stops the CPU clock and runs a request/grant/acknowledge message exchange with the processor side. For S3 and deeper targets it also parks the links in their staging state and then switches them off. It asserts suspend status and platform reset, and finally asserts one or more cumulative active-low sleep-level pins.

A wake event in any sleeping or soft-off state runs the exit sequence. The sleep-level pins are released from the deepest to the shallowest. Platform reset is released after a programmable hold time, and the CPU clock is released last. Losing AC power forces mechanical off at once. When power returns, a restore bit chooses the next state: with the bit set the block runs straight back to working, with it clear it parks in soft off and waits for a wake. Two input cycle counts set the spacing between sequence steps and the reset hold.

Top module: `sleep_state_seq`

## Requirements
- R1: While reset is applied, and from the cycle after `ac_present` is sampled low in any state, the block sits in mechanical off. In that state `state_code`=7, `cpu_clk_stop_n`=0, `msg_req`=0, `msg_ack`=0, `link_stage_req`=0, `link_off`=1, `susp_stat_n`=0, `plat_rst_n`=0 and `sleep_lvl_n`=3'b000.
- R2: When `ac_present` is high in mechanical off, `restore_on_power`=1 starts the exit sequence of R7 from the soft-off pin state and ends in working (`state_code`=0). With `restore_on_power`=0 the block moves to soft off: `state_code`=5, with every output unchanged from mechanical off.
- R3: In working, a `sleep_go` pulse is accepted only when `sleep_type` is 1, 3, 4 or 5 (S1, S3, S4, S5). Any other code, including 2, changes no output and leaves `state_code` at 0.
- R4: Every entry starts by driving `cpu_clk_stop_n` low. After the step gap, `msg_req` rises and stays high until `msg_grant` is sampled high. `msg_req` then falls and `msg_ack` is high for exactly one cycle. For target S1 the sequence ends there with `state_code`=1.
- R5: For S3 and deeper targets, after the acknowledge `link_stage_req` is held high until `link_ready` is seen. `link_stage_req` then falls as `link_off` rises. One step later `susp_stat_n` and `plat_rst_n` fall together. Both are low whenever any sleep-level pin is low.
- R6: The sleep-level pins are cumulative. Bit 0 of `sleep_lvl_n` is asserted for S3, bit 1 is added for S4 and bit 2 is added for S5. They are asserted one step apart in the order bit 0, bit 1, bit 2, and `state_code` equals the target once the last one is asserted.
- R7: On wake in a sleeping or soft-off state, the asserted sleep-level bits are released in the order 2, 1, 0, one step apart. `susp_stat_n` and `link_off` are released together with bit 0. `plat_rst_n` rises `rst_hold`+1 cycles after bit 0 is released, and `cpu_clk_stop_n` rises one step later as `state_code` returns to 0. Waking from S1 releases `cpu_clk_stop_n` on the next cycle.
- R8: `sleep_go` outside the working state and `wake_evt` outside the sleeping and soft-off states are ignored.
- R9: Each timed step lasts `step_gap`+1 cycles.
- R10: `state_code` is 6 for every cycle of an entry or exit sequence and is never 2. In working, every output is at its released level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ac_present | input | 1 | Main power present |
| restore_on_power | input | 1 | 1: return to working when power returns; 0: park in soft off |
| sleep_type | input | 3 | Requested target code (1, 3, 4, 5) |
| sleep_go | input | 1 | One-cycle request to start entry |
| wake_evt | input | 1 | Wake event |
| step_gap | input | GAP_W | Cycles per sequence step, minus one |
| rst_hold | input | GAP_W | Reset hold on exit, minus one |
| msg_grant | input | 1 | Processor side grants the clock-stop request |
| link_ready | input | 1 | Links have reached the staging state |
| cpu_clk_stop_n | output | 1 | Active-low CPU clock stop |
| msg_req | output | 1 | Clock-stop request message |
| msg_ack | output | 1 | One-cycle acknowledge message |
| link_stage_req | output | 1 | Request to move links to staging |
| link_off | output | 1 | Links off |
| susp_stat_n | output | 1 | Active-low suspend status |
| plat_rst_n | output | 1 | Active-low platform reset |
| sleep_lvl_n | output | 3 | Cumulative active-low sleep-level pins |
| state_code | output | 3 | 0 working, 1/3/4/5 sleeping, 6 in transition, 7 mechanical off |

## Verification
Entry is run to each of the four accepted targets. S1 shows that the sequence stops after the message exchange. S3, S4 and S5 show that one, two or three level pins are added, in order. Exits from each depth show that only the pins actually asserted are released, deepest first. Power restore is tried with both settings of the restore bit, and AC is dropped while a grant is being withheld, which shows the forced path to mechanical off. Rejected codes, a go or wake while an entry is in progress, a go while asleep and a wake while working all show that the state machine only listens in its resting states. Measured gaps confirm that the step and hold counts are honoured.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int unsigned LVL_CNT  = 3;
  localparam int unsigned CODE_W   = 3;

  localparam logic [CODE_W-1:0] CODE_WORK = 3'd0;
  localparam logic [CODE_W-1:0] CODE_S1   = 3'd1;
  localparam logic [CODE_W-1:0] CODE_S3   = 3'd3;
  localparam logic [CODE_W-1:0] CODE_S4   = 3'd4;
  localparam logic [CODE_W-1:0] CODE_S5   = 3'd5;
  localparam logic [CODE_W-1:0] CODE_BUSY = 3'd6;
  localparam logic [CODE_W-1:0] CODE_MOFF = 3'd7;

  typedef enum logic [3:0] {
    ST_MOFF,
    ST_WORK,
    ST_E_CLK,
    ST_E_REQ,
    ST_E_ACK,
    ST_E_LINK,
    ST_E_L3,
    ST_E_SUS,
    ST_E_LV0,
    ST_E_LV1,
    ST_E_LV2,
    ST_SLEEP,
    ST_X_LV2,
    ST_X_LV1,
    ST_X_LV0,
    ST_X_RST
  } seq_state_e;

  typedef struct packed {
    logic               clk_stop_n;
    logic               msg_req;
    logic               msg_ack;
    logic               link_req;
    logic               link_off;
    logic               susp_n;
    logic               rst_n;
    logic [LVL_CNT-1:0] lvl_n;
  } pin_set_t;

  localparam pin_set_t PINS_DOWN = '{
    clk_stop_n: 1'b0, msg_req: 1'b0, msg_ack: 1'b0, link_req: 1'b0,
    link_off: 1'b1, susp_n: 1'b0, rst_n: 1'b0, lvl_n: '0};

  localparam pin_set_t PINS_RUN = '{
    clk_stop_n: 1'b1, msg_req: 1'b0, msg_ack: 1'b0, link_req: 1'b0,
    link_off: 1'b0, susp_n: 1'b1, rst_n: 1'b1, lvl_n: '1};

  function automatic logic target_ok(input logic [CODE_W-1:0] t);
    return (t == CODE_S1) || (t == CODE_S3) || (t == CODE_S4) || (t == CODE_S5);
  endfunction

endpackage

// File: rtl/pss_rst_sync.sv
module pss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pss_gap_timer.sv
module pss_gap_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // The counter only moves while it is below saturation or being restarted.
  assign cnt_en = restart || (cnt_q != CNT_MAX);

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == limit);
endmodule

// File: rtl/pss_seq_fsm.sv
module pss_seq_fsm
  import pss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ac_present,
  input  logic              restore_on_power,
  input  logic [CODE_W-1:0] sleep_type,
  input  logic              sleep_go,
  input  logic              wake_evt,
  input  logic              msg_grant,
  input  logic              link_ready,
  input  logic              step_done,
  output seq_state_e        state_q,
  output logic [CODE_W-1:0] tgt_q,
  output pin_set_t          pins_q,
  output logic              step_restart,
  output logic              use_hold
);
  seq_state_e        state_d;
  logic [CODE_W-1:0] tgt_d;
  pin_set_t          pins_d;

  always_comb begin
    state_d       = state_q;
    tgt_d         = tgt_q;
    pins_d        = pins_q;
    pins_d.msg_ack = 1'b0;
    if (!ac_present) begin
      state_d = ST_MOFF;
      pins_d  = PINS_DOWN;
    end else begin
      unique case (state_q)
        ST_MOFF: begin
          if (restore_on_power) begin
            state_d         = ST_X_LV2;
            pins_d.lvl_n[2] = 1'b1;
          end else begin
            state_d = ST_SLEEP;
            tgt_d   = CODE_S5;
          end
        end
        ST_WORK: begin
          if (sleep_go && target_ok(sleep_type)) begin
            tgt_d             = sleep_type;
            state_d           = ST_E_CLK;
            pins_d.clk_stop_n = 1'b0;
          end
        end
        ST_E_CLK: begin
          if (step_done) begin
            state_d        = ST_E_REQ;
            pins_d.msg_req = 1'b1;
          end
        end
        ST_E_REQ: begin
          if (msg_grant) begin
            state_d        = ST_E_ACK;
            pins_d.msg_req = 1'b0;
            pins_d.msg_ack = 1'b1;
          end
        end
        ST_E_ACK: begin
          if (tgt_q == CODE_S1) begin
            state_d = ST_SLEEP;
          end else begin
            state_d         = ST_E_LINK;
            pins_d.link_req = 1'b1;
          end
        end
        ST_E_LINK: begin
          if (link_ready) begin
            state_d         = ST_E_L3;
            pins_d.link_req = 1'b0;
            pins_d.link_off = 1'b1;
          end
        end
        ST_E_L3: begin
          if (step_done) begin
            state_d       = ST_E_SUS;
            pins_d.susp_n = 1'b0;
            pins_d.rst_n  = 1'b0;
          end
        end
        ST_E_SUS: begin
          if (step_done) begin
            state_d         = ST_E_LV0;
            pins_d.lvl_n[0] = 1'b0;
          end
        end
        ST_E_LV0: begin
          if (step_done) begin
            if (tgt_q == CODE_S3) begin
              state_d = ST_SLEEP;
            end else begin
              state_d         = ST_E_LV1;
              pins_d.lvl_n[1] = 1'b0;
            end
          end
        end
        ST_E_LV1: begin
          if (step_done) begin
            if (tgt_q == CODE_S4) begin
              state_d = ST_SLEEP;
            end else begin
              state_d         = ST_E_LV2;
              pins_d.lvl_n[2] = 1'b0;
            end
          end
        end
        ST_E_LV2: begin
          if (step_done) state_d = ST_SLEEP;
        end
        ST_SLEEP: begin
          if (wake_evt) begin
            if (!pins_q.lvl_n[2]) begin
              state_d         = ST_X_LV2;
              pins_d.lvl_n[2] = 1'b1;
            end else if (!pins_q.lvl_n[1]) begin
              state_d         = ST_X_LV1;
              pins_d.lvl_n[1] = 1'b1;
            end else if (!pins_q.lvl_n[0]) begin
              state_d         = ST_X_LV0;
              pins_d.lvl_n[0] = 1'b1;
              pins_d.susp_n   = 1'b1;
              pins_d.link_off = 1'b0;
            end else begin
              state_d = ST_WORK;
              pins_d  = PINS_RUN;
            end
          end
        end
        ST_X_LV2: begin
          if (step_done) begin
            state_d         = ST_X_LV1;
            pins_d.lvl_n[1] = 1'b1;
          end
        end
        ST_X_LV1: begin
          if (step_done) begin
            state_d         = ST_X_LV0;
            pins_d.lvl_n[0] = 1'b1;
            pins_d.susp_n   = 1'b1;
            pins_d.link_off = 1'b0;
          end
        end
        ST_X_LV0: begin
          if (step_done) begin
            state_d      = ST_X_RST;
            pins_d.rst_n = 1'b1;
          end
        end
        ST_X_RST: begin
          if (step_done) begin
            state_d = ST_WORK;
            pins_d  = PINS_RUN;
          end
        end
        default: begin
          state_d = ST_MOFF;
          pins_d  = PINS_DOWN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_MOFF;
      tgt_q   <= CODE_S5;
      pins_q  <= PINS_DOWN;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      pins_q  <= pins_d;
    end
  end

  assign step_restart = (state_d != state_q);
  assign use_hold     = (state_q == ST_X_LV0);
endmodule

// File: rtl/pss_state_report.sv
module pss_state_report
  import pss_pkg::*;
(
  input  seq_state_e        state_q,
  input  logic [CODE_W-1:0] tgt_q,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    unique case (state_q)
      ST_MOFF:  code = CODE_MOFF;
      ST_WORK:  code = CODE_WORK;
      ST_SLEEP: code = tgt_q;
      default:  code = CODE_BUSY;
    endcase
  end
endmodule

// File: rtl/sleep_state_seq.sv
module sleep_state_seq
  import pss_pkg::*;
#(
  parameter int unsigned GAP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ac_present,
  input  logic               restore_on_power,
  input  logic [2:0]         sleep_type,
  input  logic               sleep_go,
  input  logic               wake_evt,
  input  logic [GAP_W-1:0]   step_gap,
  input  logic [GAP_W-1:0]   rst_hold,
  input  logic               msg_grant,
  input  logic               link_ready,
  output logic               cpu_clk_stop_n,
  output logic               msg_req,
  output logic               msg_ack,
  output logic               link_stage_req,
  output logic               link_off,
  output logic               susp_stat_n,
  output logic               plat_rst_n,
  output logic [2:0]         sleep_lvl_n,
  output logic [2:0]         state_code
);
  logic              core_rst_n;
  seq_state_e        state_q;
  logic [CODE_W-1:0] tgt_q;
  pin_set_t          pins_q;
  logic              step_restart;
  logic              use_hold;
  logic              step_done;
  logic [GAP_W-1:0]  step_limit;

  pss_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  assign step_limit = use_hold ? rst_hold : step_gap;

  pss_gap_timer #(.CNT_W(GAP_W)) u_timer (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .restart (step_restart),
    .limit   (step_limit),
    .done    (step_done)
  );

  pss_seq_fsm u_fsm (
    .clk              (clk),
    .rst_n            (core_rst_n),
    .ac_present       (ac_present),
    .restore_on_power (restore_on_power),
    .sleep_type       (sleep_type),
    .sleep_go         (sleep_go),
    .wake_evt         (wake_evt),
    .msg_grant        (msg_grant),
    .link_ready       (link_ready),
    .step_done        (step_done),
    .state_q          (state_q),
    .tgt_q            (tgt_q),
    .pins_q           (pins_q),
    .step_restart     (step_restart),
    .use_hold         (use_hold)
  );

  pss_state_report u_report (
    .state_q (state_q),
    .tgt_q   (tgt_q),
    .code    (state_code)
  );

  assign cpu_clk_stop_n = pins_q.clk_stop_n;
  assign msg_req        = pins_q.msg_req;
  assign msg_ack        = pins_q.msg_ack;
  assign link_stage_req = pins_q.link_req;
  assign link_off       = pins_q.link_off;
  assign susp_stat_n    = pins_q.susp_n;
  assign plat_rst_n     = pins_q.rst_n;
  assign sleep_lvl_n    = pins_q.lvl_n;
endmodule

// File: rtl/sleep_state_seq_chk.sv
module sleep_state_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ac_present,
  input logic       cpu_clk_stop_n,
  input logic       msg_req,
  input logic       msg_ack,
  input logic       link_stage_req,
  input logic       link_off,
  input logic       susp_stat_n,
  input logic       plat_rst_n,
  input logic [2:0] sleep_lvl_n,
  input logic [2:0] state_code
);
  assert_ac_loss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_present |=> (state_code == 3'd7 && sleep_lvl_n == 3'b000 && !plat_rst_n &&
                     !cpu_clk_stop_n && link_off && !msg_req && !susp_stat_n));

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ack |=> !msg_ack);

  assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_ack) |-> $past(msg_req));

  assert_lvl_under_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_lvl_n != 3'b111) |-> (!plat_rst_n && !susp_stat_n && !cpu_clk_stop_n));

  assert_lvl_cumulative_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_lvl_n != 3'b111) |-> (sleep_lvl_n == 3'b110 || sleep_lvl_n == 3'b100 ||
                                 sleep_lvl_n == 3'b000));

  assert_release_bit0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_lvl_n[0]) |-> (sleep_lvl_n[2:1] == 2'b11));

  assert_release_bit1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_lvl_n[1]) |-> sleep_lvl_n[2]);

  assert_rst_after_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plat_rst_n) |-> (sleep_lvl_n == 3'b111 && susp_stat_n && !cpu_clk_stop_n));

  assert_clk_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_stop_n) |-> (plat_rst_n && state_code == 3'd0));

  assert_working_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0) |-> (cpu_clk_stop_n && !msg_req && !msg_ack && !link_stage_req &&
                              !link_off && susp_stat_n && plat_rst_n && sleep_lvl_n == 3'b111));

  assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != 3'd2);
endmodule

bind sleep_state_seq sleep_state_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ac_present     (ac_present),
  .cpu_clk_stop_n (cpu_clk_stop_n),
  .msg_req        (msg_req),
  .msg_ack        (msg_ack),
  .link_stage_req (link_stage_req),
  .link_off       (link_off),
  .susp_stat_n    (susp_stat_n),
  .plat_rst_n     (plat_rst_n),
  .sleep_lvl_n    (sleep_lvl_n),
  .state_code     (state_code)
);

// File: tb/sleep_state_seq_tb_top.sv
module sleep_state_seq_tb_top;
  localparam int GW   = 8;
  localparam int GAP  = 3;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, ac_present, restore_on_power, sleep_go, wake_evt;
  logic [2:0]    sleep_type;
  logic [GW-1:0] step_gap, rst_hold;
  logic          msg_grant, link_ready;
  logic          cpu_clk_stop_n, msg_req, msg_ack, link_stage_req, link_off;
  logic          susp_stat_n, plat_rst_n;
  logic [2:0]    sleep_lvl_n, state_code;

  sleep_state_seq #(.GAP_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ac_present(ac_present), .restore_on_power(restore_on_power),
    .sleep_type(sleep_type), .sleep_go(sleep_go), .wake_evt(wake_evt),
    .step_gap(step_gap), .rst_hold(rst_hold), .msg_grant(msg_grant), .link_ready(link_ready),
    .cpu_clk_stop_n(cpu_clk_stop_n), .msg_req(msg_req), .msg_ack(msg_ack),
    .link_stage_req(link_stage_req), .link_off(link_off), .susp_stat_n(susp_stat_n),
    .plat_rst_n(plat_rst_n), .sleep_lvl_n(sleep_lvl_n), .state_code(state_code));

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 1'b0;
  bit    mon_on = 1'b0;
  bit    grant_en = 1'b1;
  bit    link_en = 1'b1;
  string cur_tag = "R1";
  logic [12:0] expq[$];

  wire [12:0] snap_now = {state_code, cpu_clk_stop_n, msg_req, msg_ack, link_stage_req,
                          link_off, susp_stat_n, plat_rst_n, sleep_lvl_n};

  function automatic logic [12:0] sn(input logic [2:0] code, input logic ck, input logic rq,
                                     input logic ak, input logic lr, input logic lo,
                                     input logic su, input logic rs, input logic [2:0] lv);
    return {code, ck, rq, ak, lr, lo, su, rs, lv};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Responders on the processor and link side.
  initial begin
    msg_grant  = 1'b0;
    link_ready = 1'b0;
    forever begin
      @(negedge clk);
      msg_grant  = grant_en & msg_req;
      link_ready = link_en & link_stage_req;
    end
  end

  // Monitor: every change of the output snapshot must match the next expected item.
  initial begin
    logic [12:0] last;
    logic [12:0] e;
    wait (mon_on);
    last = snap_now;
    forever begin
      @(negedge clk);
      if (snap_now !== last) begin
        if (expq.size() == 0) begin
          check(1'b0, {cur_tag, " unexpected change"}, {19'd0, snap_now}, {19'd0, last});
        end else begin
          e = expq.pop_front();
          check(snap_now === e, cur_tag, {19'd0, snap_now}, {19'd0, e});
        end
        last = snap_now;
      end
    end
  end

  task automatic push_entry(input logic [2:0] tgt);
    expq.push_back(sn(3'd6, 0, 0, 0, 0, 0, 1, 1, 3'b111));
    expq.push_back(sn(3'd6, 0, 1, 0, 0, 0, 1, 1, 3'b111));
    expq.push_back(sn(3'd6, 0, 0, 1, 0, 0, 1, 1, 3'b111));
    if (tgt == 3'd1) begin
      expq.push_back(sn(3'd1, 0, 0, 0, 0, 0, 1, 1, 3'b111));
    end else begin
      expq.push_back(sn(3'd6, 0, 0, 0, 1, 0, 1, 1, 3'b111));
      expq.push_back(sn(3'd6, 0, 0, 0, 0, 1, 1, 1, 3'b111));
      expq.push_back(sn(3'd6, 0, 0, 0, 0, 1, 0, 0, 3'b111));
      expq.push_back(sn(3'd6, 0, 0, 0, 0, 1, 0, 0, 3'b110));
      if (tgt >= 3'd4) expq.push_back(sn(3'd6, 0, 0, 0, 0, 1, 0, 0, 3'b100));
      if (tgt == 3'd5) expq.push_back(sn(3'd6, 0, 0, 0, 0, 1, 0, 0, 3'b000));
      expq.push_back(sn(tgt, 0, 0, 0, 0, 1, 0, 0,
                        (tgt == 3'd3) ? 3'b110 : (tgt == 3'd4) ? 3'b100 : 3'b000));
    end
  endtask

  task automatic push_exit(input logic [2:0] from);
    if (from == 3'd1) begin
      expq.push_back(sn(3'd0, 1, 0, 0, 0, 0, 1, 1, 3'b111));
    end else begin
      if (from == 3'd5) expq.push_back(sn(3'd6, 0, 0, 0, 0, 1, 0, 0, 3'b100));
      if (from >= 3'd4) expq.push_back(sn(3'd6, 0, 0, 0, 0, 1, 0, 0, 3'b110));
      expq.push_back(sn(3'd6, 0, 0, 0, 0, 0, 1, 0, 3'b111));
      expq.push_back(sn(3'd6, 0, 0, 0, 0, 0, 1, 1, 3'b111));
      expq.push_back(sn(3'd0, 1, 0, 0, 0, 0, 1, 1, 3'b111));
    end
  endtask

  task automatic go(input logic [2:0] t);
    @(negedge clk);
    sleep_type = t;
    sleep_go   = 1'b1;
    @(negedge clk);
    sleep_go   = 1'b0;
  endtask

  task automatic wake();
    @(negedge clk);
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3000 && expq.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, {tag, " sequence incomplete"}, expq.size(), 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; ac_present = 1'b0; restore_on_power = 1'b1;
    sleep_type = 3'd0; sleep_go = 1'b0; wake_evt = 1'b0;
    step_gap = GW'(GAP); rst_hold = GW'(HOLD);
    repeat (3) @(negedge clk);
    // R1: mechanical off under reset
    check(snap_now === sn(3'd7, 0, 0, 0, 0, 1, 0, 0, 3'b000), "R1 reset", snap_now,
          sn(3'd7, 0, 0, 0, 0, 1, 0, 0, 3'b000));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(state_code === 3'd7, "R1 no AC after reset", state_code, 7);
    mon_on = 1'b1;

    // R2: restore with the bit set runs back to working
    cur_tag = "R2 restore";
    push_exit(3'd5);
    ac_present = 1'b1;
    drain("R2");
    check(state_code === 3'd0, "R2 working after restore", state_code, 0);

    // R3: rejected codes
    cur_tag = "R3";
    go(3'd2); go(3'd0); go(3'd7); go(3'd6);
    repeat (20) @(negedge clk);
    check(state_code === 3'd0 && cpu_clk_stop_n === 1'b1, "R3 rejected codes",
          state_code, 0);

    // R4: S1 entry, then wake (R7)
    cur_tag = "R4 R10 entry S1";
    push_entry(3'd1); go(3'd1); drain("R4");
    check(state_code === 3'd1, "R4 S1 reached", state_code, 1);
    cur_tag = "R7 exit S1";
    push_exit(3'd1); wake(); drain("R7");
    check(state_code === 3'd0, "R7 working after S1", state_code, 0);

    // R5, R6: S3 entry; R8: go while asleep is ignored
    cur_tag = "R5 R6 entry S3";
    push_entry(3'd3); go(3'd3); drain("R5");
    check(state_code === 3'd3, "R6 S3 reached", state_code, 3);
    cur_tag = "R8 go in sleep";
    go(3'd5);
    repeat (15) @(negedge clk);
    check(state_code === 3'd3 && sleep_lvl_n === 3'b110, "R8 go while asleep",
          {state_code, sleep_lvl_n}, {3'd3, 3'b110});
    cur_tag = "R7 exit S3";
    push_exit(3'd3); wake(); drain("R7");

    // R9: step length; R8: go and wake during entry
    cur_tag = "R6 R8 entry S4";
    push_entry(3'd4); go(3'd4);
    for (int i = 0; i < 500 && link_off !== 1'b1; i++) @(negedge clk);
    @(negedge clk);
    sleep_type = 3'd5; sleep_go = 1'b1; wake_evt = 1'b1;
    @(negedge clk);
    sleep_go = 1'b0; wake_evt = 1'b0;
    for (int i = 0; i < 500 && sleep_lvl_n !== 3'b110; i++) @(negedge clk);
    n = 0;
    while (sleep_lvl_n !== 3'b100 && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(n == GAP + 1, "R9 step length", n, GAP + 1);
    drain("R8");
    check(state_code === 3'd4, "R8 S4 reached despite go and wake", state_code, 4);

    // R7: reset hold on exit from S4
    cur_tag = "R7 exit S4";
    push_exit(3'd4); wake();
    for (int i = 0; i < 500 && sleep_lvl_n !== 3'b111; i++) @(negedge clk);
    n = 0;
    while (plat_rst_n !== 1'b1 && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(n == HOLD + 1, "R7 reset hold", n, HOLD + 1);
    drain("R7");

    // R6: S5 entry and exit
    cur_tag = "R6 entry S5";
    push_entry(3'd5); go(3'd5); drain("R6");
    check(state_code === 3'd5 && sleep_lvl_n === 3'b000, "R6 S5 reached",
          {state_code, sleep_lvl_n}, {3'd5, 3'b000});
    cur_tag = "R7 exit S5";
    push_exit(3'd5); wake(); drain("R7");

    // R8: wake while working
    cur_tag = "R8 wake in working";
    wake();
    repeat (10) @(negedge clk);
    check(state_code === 3'd0, "R8 wake in working", state_code, 0);

    // R1: AC loss during entry; R10 busy code
    cur_tag = "R1 AC loss";
    grant_en = 1'b0;
    expq.push_back(sn(3'd6, 0, 0, 0, 0, 0, 1, 1, 3'b111));
    expq.push_back(sn(3'd6, 0, 1, 0, 0, 0, 1, 1, 3'b111));
    go(3'd3);
    for (int i = 0; i < 500 && msg_req !== 1'b1; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(state_code === 3'd6, "R10 busy code", state_code, 6);
    expq.push_back(sn(3'd7, 0, 0, 0, 0, 1, 0, 0, 3'b000));
    ac_present = 1'b0;
    repeat (3) @(negedge clk);
    check(state_code === 3'd7 && expq.size() == 0, "R1 AC loss", state_code, 7);
    grant_en = 1'b1;

    // R2: restore with the bit clear parks in soft off
    cur_tag = "R2 park";
    restore_on_power = 1'b0;
    expq.push_back(sn(3'd5, 0, 0, 0, 0, 1, 0, 0, 3'b000));
    ac_present = 1'b1;
    drain("R2");
    check(state_code === 3'd5, "R2 soft off", state_code, 5);
    cur_tag = "R7 exit soft off";
    push_exit(3'd5); wake(); drain("R7");
    check(state_code === 3'd0, "R7 working after soft off", state_code, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule